// File: doc/BRIEF.md
# Address-Snooping Character Bank Mapper

This block is the banking logic of a game cartridge that serves two address spaces. On the processor side, any write into the upper half of the address map loads a small bank register. Its low bits choose a 32 KiB program ROM bank and one further bit chooses which 16 KiB half of a 32 KiB character RAM is in use. The value stored is not simply the written byte. The ROM drives the data bus at the same moment, so the register takes the bitwise AND of the written byte and the ROM byte.

On the video side, the block never receives the inner character bank as data. Instead it watches the graphics address bus on every system clock. When that address moves into the $2xxx nametable window from anywhere else, address bits 9:8 are captured as the inner bank. Graphics read and write strobes play no part, so addresses that the processor sets through the video address port trigger capture in the same way as fetches made by the video chip. The captured value and graphics address bit 12 pass through inverting NOR gating to form the physical page. The lower pattern table therefore walks the pages in reversed order, and the upper pattern table always sits on physical page 0 of the selected half.

The outputs are the program ROM address and the full character RAM address. Both are formed combinationally from the registered bank state and the live address inputs.

Top module: `snoop_chr_mapper`

## Requirements
- R1: After reset the program bank, the outer character block and the captured inner value are all 0. prg_addr is then {2'b00, cpu_addr[14:0]}, and chr_addr for a graphics address below $1000 is {1'b0, 2'b11, ppu_addr[11:0]}.
- R2: The bank register loads only on a clock edge where cpu_wr is 1 and cpu_addr[15] is 1. With cpu_wr at 0, or with cpu_addr below $8000, prg_addr[16:15] and chr_addr[14] keep their values.
- R3: A register write stores cpu_wdata AND rom_rdata. A bit that either side drives low is stored as 0.
- R4: Bits 1:0 of the stored byte appear as prg_addr[16:15] and bit 2 appears uninverted as chr_addr[14]. Bits 7:3 have no effect on any output. prg_addr[14:0] is cpu_addr[14:0].
- R5: The inner value is loaded from ppu_addr[9:8] on a clock edge where ppu_addr[13] is 1 and ppu_addr[12] is 0, provided that the same condition was false at the previous edge (or reset was active there).
- R6: While the graphics address stays in $2xxx across consecutive edges, the inner value does not change. This includes a move from a tile entry to an attribute entry such as $23C0-$23FF.
- R7: Addresses in $0xxx, $1xxx and $3xxx never load the inner value. A move from $3xxx into $2xxx does load it.
- R8: A move into $2xxx that lands on $23C0-$23FF loads the inner value 3, the same as any other $23xx address.
- R9: chr_addr[13:12] is the bitwise NOR of the inner value with ppu_addr[12]. Below $1000 this gives physical pages 3,2,1,0 for inner values 0,1,2,3. For $1000-$1FFF it is always 0.
- R10: chr_addr[11:0] equals ppu_addr[11:0], and chr_addr updates in the same cycle as any change of ppu_addr.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every edge samples both address buses |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Processor write strobe, one cycle per write |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Byte driven by the processor on a write |
| rom_rdata | input | 8 | Byte driven by the program ROM at cpu_addr |
| ppu_addr | input | 14 | Graphics address bus |
| prg_addr | output | 17 | Program ROM address: bank bits above cpu_addr[14:0] |
| chr_addr | output | 15 | Character RAM address: outer bit, physical page, offset |

## Verification
A corrupted bank register shows on prg_addr[16:15] or chr_addr[14] on the first cycle after the write, and the error persists until the next write. A wrong inner value or a wrong previous-window flag appears as a wrong physical page in chr_addr[13:12] on the first cycle that the graphics address is below $1000. A spurious recapture inside $2xxx shows as a page change while the address only wanders inside the window. Sweeping every graphics address in order, and then hopping at random between addresses, exposes both kinds of fault within a few cycles of their cause.

// File: rtl/snoop_mapper_pkg.sv
package snoop_mapper_pkg;

   // How the processor write meets the ROM byte on the shared bus
   typedef enum logic {
      CONFLICT_AND  = 1'b0,
      CONFLICT_NONE = 1'b1
   } conflict_mode_e;

   // How the captured value and the pattern-table select form the page
   typedef enum logic {
      GATE_NOR = 1'b0,
      GATE_OR  = 1'b1
   } gate_mode_e;

   // Nametable window decode: upper select high, pattern select low
   function automatic logic in_window(input logic sel_hi, input logic sel_lo);
      return sel_hi & ~sel_lo;
   endfunction

endpackage

// File: rtl/cpu_bank_reg.sv
module cpu_bank_reg
   import snoop_mapper_pkg::*;
#(
   parameter int             DATA_W     = 8,
   parameter int             PRG_BANK_W = 2,
   parameter int             OUTER_BIT  = 2,
   parameter conflict_mode_e CONFLICT   = CONFLICT_AND
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [DATA_W-1:0]     wdata,
   input  logic [DATA_W-1:0]     rdata,
   output logic [PRG_BANK_W-1:0] prg_bank,
   output logic                  outer_sel
);

   logic [DATA_W-1:0] bus_val;

   generate
      if (CONFLICT == CONFLICT_AND) begin : g_conflict
         assign bus_val = wdata & rdata;
      end else begin : g_clean
         assign bus_val = wdata;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prg_bank  <= '0;
         outer_sel <= 1'b0;
      end else if (load) begin
         prg_bank  <= bus_val[PRG_BANK_W-1:0];
         outer_sel <= bus_val[OUTER_BIT];
      end
   end

endmodule

// File: rtl/nt_edge_snooper.sv
module nt_edge_snooper
   import snoop_mapper_pkg::*;
#(
   parameter int VA_W       = 14,
   parameter int PAGE_OFS_W = 12,
   parameter int CAP_LSB    = 8,
   parameter int INNER_W    = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VA_W-1:0]    va,
   output logic [INNER_W-1:0] inner
);

   localparam int SEL_LO = PAGE_OFS_W;
   localparam int SEL_HI = PAGE_OFS_W + 1;

   logic now_in;
   logic was_in;
   logic enter;

   assign now_in = in_window(va[SEL_HI], va[SEL_LO]);
   assign enter  = now_in & ~was_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         was_in <= 1'b0;
         inner  <= '0;
      end else begin
         was_in <= now_in;
         if (enter) inner <= va[CAP_LSB +: INNER_W];
      end
   end

endmodule

// File: rtl/chr_addr_former.sv
module chr_addr_former
   import snoop_mapper_pkg::*;
#(
   parameter int         VA_W       = 14,
   parameter int         PAGE_OFS_W = 12,
   parameter int         INNER_W    = 2,
   parameter gate_mode_e GATE       = GATE_NOR,
   localparam int        OUT_W      = 1 + INNER_W + PAGE_OFS_W
)(
   input  logic               outer_sel,
   input  logic [INNER_W-1:0] inner,
   input  logic [VA_W-1:0]    va,
   output logic [OUT_W-1:0]   chr_addr
);

   logic [INNER_W-1:0] upper_mask;
   logic [INNER_W-1:0] page;

   assign upper_mask = {INNER_W{va[PAGE_OFS_W]}};

   generate
      if (GATE == GATE_NOR) begin : g_nor
         assign page = ~(inner | upper_mask);
      end else begin : g_or
         assign page = inner | upper_mask;
      end
   endgenerate

   assign chr_addr = {outer_sel, page, va[PAGE_OFS_W-1:0]};

endmodule

// File: rtl/snoop_chr_mapper.sv
module snoop_chr_mapper
   import snoop_mapper_pkg::*;
#(
   parameter int             CPU_ADDR_W = 16,
   parameter int             DATA_W     = 8,
   parameter int             PRG_BANK_W = 2,
   parameter int             OUTER_BIT  = 2,
   parameter int             VA_W       = 14,
   parameter int             PAGE_OFS_W = 12,
   parameter int             CAP_LSB    = 8,
   parameter int             INNER_W    = 2,
   parameter conflict_mode_e CONFLICT   = CONFLICT_AND,
   parameter gate_mode_e     GATE       = GATE_NOR,
   localparam int            PRG_ADDR_W = PRG_BANK_W + CPU_ADDR_W - 1,
   localparam int            CHR_ADDR_W = 1 + INNER_W + PAGE_OFS_W
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cpu_wr,
   input  logic [CPU_ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0]     cpu_wdata,
   input  logic [DATA_W-1:0]     rom_rdata,
   input  logic [VA_W-1:0]       ppu_addr,
   output logic [PRG_ADDR_W-1:0] prg_addr,
   output logic [CHR_ADDR_W-1:0] chr_addr
);

   generate
      if (VA_W != PAGE_OFS_W + 2) begin : g_bad_va
         $error("graphics bus must be page offset plus two select bits");
      end
      if (CAP_LSB + INNER_W > PAGE_OFS_W) begin : g_bad_cap
         $error("captured field must lie inside the page offset");
      end
      if (OUTER_BIT < PRG_BANK_W || OUTER_BIT >= DATA_W) begin : g_bad_outer
         $error("outer select bit must sit above the program bank field");
      end
      if (CPU_ADDR_W < 2) begin : g_bad_cpu
         $error("processor address too narrow");
      end
   endgenerate

   logic                  reg_load;
   logic [PRG_BANK_W-1:0] prg_bank;
   logic                  outer_sel;
   logic [INNER_W-1:0]    inner;

   assign reg_load = cpu_wr & cpu_addr[CPU_ADDR_W-1];

   cpu_bank_reg #(
      .DATA_W     (DATA_W),
      .PRG_BANK_W (PRG_BANK_W),
      .OUTER_BIT  (OUTER_BIT),
      .CONFLICT   (CONFLICT)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (reg_load),
      .wdata     (cpu_wdata),
      .rdata     (rom_rdata),
      .prg_bank  (prg_bank),
      .outer_sel (outer_sel)
   );

   nt_edge_snooper #(
      .VA_W       (VA_W),
      .PAGE_OFS_W (PAGE_OFS_W),
      .CAP_LSB    (CAP_LSB),
      .INNER_W    (INNER_W)
   ) u_snoop (
      .clk   (clk),
      .rst_n (rst_n),
      .va    (ppu_addr),
      .inner (inner)
   );

   chr_addr_former #(
      .VA_W       (VA_W),
      .PAGE_OFS_W (PAGE_OFS_W),
      .INNER_W    (INNER_W),
      .GATE       (GATE)
   ) u_chr (
      .outer_sel (outer_sel),
      .inner     (inner),
      .va        (ppu_addr),
      .chr_addr  (chr_addr)
   );

   assign prg_addr = {prg_bank, cpu_addr[CPU_ADDR_W-2:0]};

endmodule

// File: rtl/snoop_chr_mapper_chk.sv
module snoop_chr_mapper_chk
   import snoop_mapper_pkg::*;
#(
   parameter int             CPU_ADDR_W = 16,
   parameter int             DATA_W     = 8,
   parameter int             PRG_BANK_W = 2,
   parameter int             OUTER_BIT  = 2,
   parameter int             VA_W       = 14,
   parameter int             PAGE_OFS_W = 12,
   parameter int             CAP_LSB    = 8,
   parameter int             INNER_W    = 2,
   parameter conflict_mode_e CONFLICT   = CONFLICT_AND,
   parameter gate_mode_e     GATE       = GATE_NOR,
   localparam int            PRG_ADDR_W = PRG_BANK_W + CPU_ADDR_W - 1,
   localparam int            CHR_ADDR_W = 1 + INNER_W + PAGE_OFS_W
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cpu_wr,
   input logic [CPU_ADDR_W-1:0] cpu_addr,
   input logic [DATA_W-1:0]     cpu_wdata,
   input logic [DATA_W-1:0]     rom_rdata,
   input logic [VA_W-1:0]       ppu_addr,
   input logic [PRG_ADDR_W-1:0] prg_addr,
   input logic [CHR_ADDR_W-1:0] chr_addr
);

   localparam int SEL_LO = PAGE_OFS_W;
   localparam int SEL_HI = PAGE_OFS_W + 1;

   logic               hit;
   logic               win_now;
   logic               win_prev;
   logic               rise;
   logic [INNER_W-1:0] page;
   logic [PRG_BANK_W-1:0] bank_out;

   assign hit      = cpu_wr & cpu_addr[CPU_ADDR_W-1];
   assign win_now  = ppu_addr[SEL_HI] & ~ppu_addr[SEL_LO];
   assign rise     = win_now & ~win_prev;
   assign page     = chr_addr[PAGE_OFS_W +: INNER_W];
   assign bank_out = prg_addr[PRG_ADDR_W-1 -: PRG_BANK_W];

   always_ff @(posedge clk) begin
      if (!rst_n) win_prev <= 1'b0;
      else        win_prev <= win_now;
   end

   AST_IDLE_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(bank_out)); // R2
   AST_IDLE_OUTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(chr_addr[CHR_ADDR_W-1])); // R2

   generate
      if (CONFLICT == CONFLICT_AND) begin : g_conf
         AST_BANK_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> bank_out == $past(cpu_wdata[PRG_BANK_W-1:0] & rom_rdata[PRG_BANK_W-1:0])); // R3
         AST_OUTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            hit |=> chr_addr[CHR_ADDR_W-1] == $past(cpu_wdata[OUTER_BIT] & rom_rdata[OUTER_BIT])); // R4
      end
      if (GATE == GATE_NOR) begin : g_nor
         AST_UPPER_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            ppu_addr[SEL_LO] |-> page == '0); // R9
         AST_ENTRY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            rise |=> (ppu_addr[SEL_LO] || page == ~$past(ppu_addr[CAP_LSB +: INNER_W]))); // R5
         AST_NO_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
            (!rise && !ppu_addr[SEL_LO]) |=> (ppu_addr[SEL_LO] || page == $past(page))); // R6
      end
   endgenerate

   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(ppu_addr) |-> $stable(chr_addr[PAGE_OFS_W-1:0])); // R10

endmodule

bind snoop_chr_mapper snoop_chr_mapper_chk #(
   .CPU_ADDR_W (CPU_ADDR_W),
   .DATA_W     (DATA_W),
   .PRG_BANK_W (PRG_BANK_W),
   .OUTER_BIT  (OUTER_BIT),
   .VA_W       (VA_W),
   .PAGE_OFS_W (PAGE_OFS_W),
   .CAP_LSB    (CAP_LSB),
   .INNER_W    (INNER_W),
   .CONFLICT   (CONFLICT),
   .GATE       (GATE)
) u_chk (.*);

// File: tb/snoop_chr_mapper_tb.sv
module snoop_chr_mapper_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [15:0] cpu_addr = 16'h8123;
   logic [7:0]  cpu_wdata = 8'h00;
   logic [7:0]  rom_rdata = 8'h00;
   logic [13:0] ppu_addr = 14'h0456;
   logic [16:0] prg_addr;
   logic [14:0] chr_addr;

   always #4 clk = ~clk;

   snoop_chr_mapper u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_wr    (cpu_wr),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .rom_rdata (rom_rdata),
      .ppu_addr  (ppu_addr),
      .prg_addr  (prg_addr),
      .chr_addr  (chr_addr)
   );

   int n_cmp = 0;
   int n_bad = 0;

   logic [1:0] m_bank  = 2'd0;
   logic [1:0] m_inner = 2'd0;
   logic       m_outer = 1'b0;
   logic       m_prev  = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [14:0] exp_chr();
      return {m_outer, ~(m_inner | {2{ppu_addr[12]}}), ppu_addr[11:0]};
   endfunction

   function automatic logic [16:0] exp_prg();
      return {m_bank, cpu_addr[14:0]};
   endfunction

   // One clock edge; the model follows the requirements, then outputs settle
   task automatic tick();
      logic [7:0] v;
      logic       c;
      @(posedge clk);
      if (cpu_wr && cpu_addr[15]) begin
         v = cpu_wdata & rom_rdata;
         m_bank  = v[1:0];
         m_outer = v[2];
      end
      c = ppu_addr[13] & ~ppu_addr[12];
      if (c && !m_prev) m_inner = ppu_addr[9:8];
      m_prev = c;
      #2;
   endtask

   task automatic check_both(input string req);
      chk(req, 32'(prg_addr), 32'(exp_prg()));
      chk(req, 32'(chr_addr), 32'(exp_chr()));
   endtask

   task automatic visit(input logic [13:0] a, input string req);
      ppu_addr = a;
      tick();
      chk(req, 32'(chr_addr), 32'(exp_chr()));
   endtask

   task automatic load_reg(input logic [7:0] w, input logic [7:0] r);
      cpu_wr = 1'b1; cpu_addr = 16'hC000; cpu_wdata = w; rom_rdata = r;
      tick();
      cpu_wr = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] lf;
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      // R1: reset state seen at the ports
      chk("R1", 32'(prg_addr), 32'h00123);
      chk("R1", 32'(chr_addr), 32'h3456);

      // R3 R4: write sweep against several ROM patterns
      ppu_addr = 14'h0000;
      for (int w = 0; w < 256; w++) begin
         for (int p = 0; p < 4; p++) begin
            cpu_wr    = 1'b1;
            cpu_addr  = 16'h8000 | 16'((w * 37 + p * 911) & 16'h7FFF);
            cpu_wdata = 8'(w);
            rom_rdata = (p == 0) ? 8'hFF : (p == 1) ? 8'h00 : (p == 2) ? 8'hAA : 8'(~w ^ 8'h05);
            tick();
            check_both("R3_R4");
         end
      end

      // R2: writes below $8000 and idle cycles change nothing
      load_reg(8'h06, 8'hFF);
      check_both("R2");
      for (int i = 0; i < 32; i++) begin
         cpu_wr    = 1'(i & 1);
         cpu_addr  = (i & 1) ? 16'(i * 1021 & 16'h7FFF) : 16'(16'h8000 | i * 77);
         cpu_wdata = 8'(~i);
         rom_rdata = 8'hFF;
         tick();
         chk("R2", 32'(prg_addr[16:15]), 32'h2);
         chk("R2", 32'(chr_addr[14]), 32'h1);
      end
      cpu_wr = 1'b0;

      // R5 R6 R7 R8 R9: directed transitions
      visit(14'h0100, "R7");
      visit(14'h2345, "R5");
      chk("R5", 32'(chr_addr[13:12]), 32'h0);
      visit(14'h23C1, "R6");
      visit(14'h0000, "R6");
      chk("R6", 32'(chr_addr[13:12]), 32'h0);
      visit(14'h2100, "R5");
      visit(14'h23C1, "R6");
      visit(14'h0ABC, "R6");
      chk("R6", 32'(chr_addr[13:12]), 32'h2);
      visit(14'h3000, "R7");
      visit(14'h3FFF, "R7");
      visit(14'h0ABC, "R7");
      chk("R7", 32'(chr_addr[13:12]), 32'h2);
      visit(14'h3000, "R7");
      visit(14'h23D0, "R8");
      visit(14'h0001, "R8");
      chk("R8", 32'(chr_addr[13:12]), 32'h0);
      visit(14'h1000, "R9");
      visit(14'h2200, "R9");
      chk("R9", 32'(chr_addr[13:12]), 32'h1);
      visit(14'h1ABC, "R9");
      chk("R9", 32'(chr_addr), 32'h4ABC);

      // R9 R10: full in-order sweep of the graphics space in each outer block
      for (int blk = 0; blk < 2; blk++) begin
         load_reg(blk == 0 ? 8'hF8 : 8'hFD, 8'hFF);
         for (int a = 0; a < 16384; a++) visit(14'(a), "R10");
      end

      // R2-R10: random hops with concurrent processor traffic
      lf = 16'hACE1;
      for (int i = 0; i < 20000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         ppu_addr  = lf[13:0];
         cpu_wr    = lf[3] & lf[9];
         cpu_addr  = {lf[2], lf[14:0]};
         cpu_wdata = lf[15:8];
         rom_rdata = lf[7:0] | 8'h30;
         tick();
         check_both("R9");
      end
      cpu_wr = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule